// File: doc/BRIEF.md
# Command-word watchdog counter

This block is a 20-bit down-counting watchdog that advances only on a single-cycle trigger pulse from an upstream time-base prescaler. Software never touches a control bit directly. It writes 16-bit magic words into a write-only command port, and each recognised word unlocks or locks the count register, pauses or resumes counting, clears the expiry flag or reloads the counter to full scale. Any other word does nothing.

The count register shows only bits 19:4 of the counter. A write places the 16-bit value into those bits and zeroes the four hidden low bits, so the timeout has a granularity of 16 trigger pulses. When the counter lands on zero, a level flag rises in the same cycle. The flag stays set until software sends the clear word. On the next trigger after zero, the counter wraps back to full scale and keeps running. System-reset generation and the bus decode sit outside the block.

Top module: `cmd_watchdog`

## Requirements
- R1: After reset the counter holds all ones (count port reads 0xFFFF), irq_o is low, the watchdog is paused and writes to the count register are unlocked.
- R2: Command 0xAB01 locks the count register, and 0xAB00 unlocks it. While locked, a count write leaves the counter unchanged.
- R3: Command 0x3877 pauses the counter, which then holds its value across trigger pulses. Command 0x4A4B resumes counting.
- R4: While running, each cycle with tick_i high decrements the counter by one. Cycles without tick_i leave it unchanged.
- R5: cnt_rdata_o always shows counter bits 19:4. An unlocked count write loads cnt_wdata_i into bits 19:4 and clears bits 3:0.
- R6: irq_o rises in the same cycle the counter changes from non-zero to zero, and then stays high until cleared.
- R7: Command 0x7482 clears irq_o. If the counter reaches zero in that same cycle, the flag is set instead.
- R8: Command 0xDEAF loads the counter with all ones. An unlocked count write in the same cycle takes priority over it.
- R9: A trigger pulse while running with the counter at zero reloads the counter to all ones.
- R10: Command words other than the six codes above change nothing. Lock and pause states persist until a command changes them.
- R11: A lock or pause command takes effect from the following cycle. An unlocked count write takes priority over a trigger in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle trigger pulse from the time-base prescaler |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_data_i | input | 16 | Command word |
| cnt_we_i | input | 1 | Count register write strobe |
| cnt_wdata_i | input | 16 | New value for counter bits 19:4 |
| cnt_rdata_o | output | 16 | Counter bits 19:4 |
| irq_o | output | 1 | Sticky expiry flag |

## Verification
The bench uses the default parameters: a 20-bit counter with 4 hidden low bits. A full run from reset would take about a million triggers, so the bench reaches expiry by writing small values such as 0x0001 into the visible field. That value puts the counter sixteen triggers from zero, which makes the zero crossing, the sticky flag, the wrap to full scale and a clear colliding with expiry all reachable within a few dozen cycles. A random phase then mixes all command words, invalid words, writes and triggers, keeping written values small so that expiry happens often.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CMD_W = 16;
  localparam logic [CMD_W-1:0] CMD_UNLOCK = 16'hAB00;
  localparam logic [CMD_W-1:0] CMD_LOCK   = 16'hAB01;
  localparam logic [CMD_W-1:0] CMD_PAUSE  = 16'h3877;
  localparam logic [CMD_W-1:0] CMD_RESUME = 16'h4A4B;
  localparam logic [CMD_W-1:0] CMD_CLR    = 16'h7482;
  localparam logic [CMD_W-1:0] CMD_MAXLD  = 16'hDEAF;

  typedef struct packed {
    logic unlock;
    logic lock;
    logic pause;
    logic resume;
    logic clr;
    logic maxld;
  } wd_cmd_t;
endpackage

// File: rtl/wdog_cmd_dec.sv
module wdog_cmd_dec
  import wdog_pkg::*;
(
  input  logic             we_i,
  input  logic [CMD_W-1:0] data_i,
  output wd_cmd_t          cmd_o
);
  always_comb begin
    cmd_o = '0;
    if (we_i) begin
      unique case (data_i)
        CMD_UNLOCK: cmd_o.unlock = 1'b1;
        CMD_LOCK:   cmd_o.lock   = 1'b1;
        CMD_PAUSE:  cmd_o.pause  = 1'b1;
        CMD_RESUME: cmd_o.resume = 1'b1;
        CMD_CLR:    cmd_o.clr    = 1'b1;
        CMD_MAXLD:  cmd_o.maxld  = 1'b1;
        default:    cmd_o        = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_mode_regs.sv
module wdog_mode_regs
  import wdog_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  wd_cmd_t cmd_i,
  output logic    locked_o,
  output logic    paused_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b0;
      paused_o <= 1'b1;
    end else begin
      if (cmd_i.lock)        locked_o <= 1'b1;
      else if (cmd_i.unlock) locked_o <= 1'b0;
      if (cmd_i.pause)       paused_o <= 1'b1;
      else if (cmd_i.resume) paused_o <= 1'b0;
    end
  end

  p_lock_takes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.lock |=> locked_o);
  p_pause_takes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.pause |=> paused_o);
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned LOW_W = 4,
  localparam int unsigned VIS_W = CNT_W - LOW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             paused_i,
  input  logic             locked_i,
  input  logic             wr_i,
  input  logic [VIS_W-1:0] wdata_i,
  input  logic             maxld_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d, wr_en, hit;

  assign wr_en = wr_i && !locked_i;

  // priority: count write, then max reload, then trigger
  always_comb begin
    cnt_d = cnt_q;
    if (wr_en)                     cnt_d = {wdata_i, {LOW_W{1'b0}}};
    else if (maxld_i)              cnt_d = MAXV;
    else if (tick_i && !paused_i)  cnt_d = (cnt_q == '0) ? MAXV : cnt_q - ONE;
    hit    = (cnt_d == '0) && (cnt_q != '0);
    flag_d = hit ? 1'b1 : (clr_i ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= MAXV;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  p_hold_paused_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_i && !wr_i && !maxld_i |=> $stable(cnt_q));
  p_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !paused_i && !wr_i && !maxld_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - ONE);
  p_low_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !locked_i |=> cnt_q[LOW_W-1:0] == '0);
  p_zero_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) && ($past(cnt_q) != '0) |-> flag_q);
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q);
  p_maxld_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    maxld_i && !wr_i |=> cnt_q == MAXV);
  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !paused_i && !wr_i && !maxld_i && cnt_q == '0 |=> cnt_q == MAXV);
endmodule

// File: rtl/cmd_watchdog.sv
module cmd_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned LOW_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   cmd_we_i,
  input  logic [CMD_W-1:0]       cmd_data_i,
  input  logic                   cnt_we_i,
  input  logic [CNT_W-LOW_W-1:0] cnt_wdata_i,
  output logic [CNT_W-LOW_W-1:0] cnt_rdata_o,
  output logic                   irq_o
);
  localparam int unsigned VIS_W = CNT_W - LOW_W;

  wd_cmd_t          cmd;
  logic             locked, paused;
  logic [CNT_W-1:0] cnt;

  wdog_cmd_dec u_dec (
    .we_i   (cmd_we_i),
    .data_i (cmd_data_i),
    .cmd_o  (cmd)
  );

  wdog_mode_regs u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd),
    .locked_o (locked),
    .paused_o (paused)
  );

  wdog_core #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .paused_i (paused),
    .locked_i (locked),
    .wr_i     (cnt_we_i),
    .wdata_i  (cnt_wdata_i),
    .maxld_i  (cmd.maxld),
    .clr_i    (cmd.clr),
    .cnt_o    (cnt),
    .flag_o   (irq_o)
  );

  assign cnt_rdata_o = cnt[CNT_W-1:LOW_W];

  p_locked_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i && locked && !cmd.maxld && !tick_i |=> $stable(cnt_rdata_o));
  p_bad_cmd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == '0 |=> $stable(locked) && $stable(paused));
  p_vis_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i && !locked |=> cnt_rdata_o == $past(cnt_wdata_i));
  initial assert (VIS_W > 0);
endmodule

// File: tb/sim_cmd_watchdog.sv
module sim_cmd_watchdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, cmd_we = 1'b0, cnt_we = 1'b0;
  logic [15:0] cmd_data = '0, cnt_wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference
  int m_cnt = 'hFFFFF;
  bit m_lock = 0, m_pause = 1, m_flag = 0;

  always #10 clk = ~clk;

  cmd_watchdog u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cmd_we_i(cmd_we),
    .cmd_data_i(cmd_data), .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
    .cnt_rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 'hFFFFF; m_lock = 0; m_pause = 1; m_flag = 0;
    end else begin
      int nxt;
      bit clr, mx, nl, np;
      clr = 0; mx = 0; nl = m_lock; np = m_pause;
      if (cmd_we) begin
        if (cmd_data == 16'hAB00) nl = 0;
        if (cmd_data == 16'hAB01) nl = 1;
        if (cmd_data == 16'h3877) np = 1;
        if (cmd_data == 16'h4A4B) np = 0;
        if (cmd_data == 16'h7482) clr = 1;
        if (cmd_data == 16'hDEAF) mx = 1;
      end
      nxt = m_cnt;
      if (cnt_we && !m_lock) nxt = int'(cnt_wdata) * 16;
      else if (mx) nxt = 'hFFFFF;
      else if (tick && !m_pause) nxt = (m_cnt == 0) ? 'hFFFFF : m_cnt - 1;
      if (nxt == 0 && m_cnt != 0) m_flag = 1;
      else if (clr) m_flag = 0;
      m_cnt = nxt; m_lock = nl; m_pause = np;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk({phase, " read"}, int'(rdata), m_cnt / 16);
    chk({phase, " irq"}, int'(irq), int'(m_flag));
  end

  task automatic step(input bit cw, input logic [15:0] cd, input bit ww,
                      input logic [15:0] wd, input bit tk);
    cmd_we = cw; cmd_data = cd; cnt_we = ww; cnt_wdata = wd; tick = tk;
    @(negedge clk);
    cmd_we = 0; cnt_we = 0; tick = 0;
  endtask

  task automatic cmd(input logic [15:0] c); step(1, c, 0, 0, 0); endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1); endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset read", int'(rdata), 'hFFFF);
    chk("R1 reset irq", int'(irq), 0);
    phase = "R1";
    ticks(5);
    chk("R1 paused after reset", int'(rdata), 'hFFFF);
    phase = "R5";
    step(0, 0, 1, 16'h0001, 0);
    chk("R5 write visible bits", int'(rdata), 1);
    phase = "R4";
    cmd(16'h4A4B);
    step(0, 0, 0, 0, 0);
    chk("R4 no tick no change", int'(rdata), 1);
    ticks(1);
    chk("R5 low bits cleared by write", int'(rdata), 0);
    ticks(14);
    chk("R6 irq low before zero", int'(irq), 0);
    phase = "R6";
    ticks(1);
    chk("R6 irq on zero", int'(irq), 1);
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    chk("R6 irq sticky", int'(irq), 1);
    phase = "R9";
    ticks(1);
    chk("R9 wrap to max", int'(rdata), 'hFFFF);
    chk("R6 irq held after wrap", int'(irq), 1);
    phase = "R7";
    cmd(16'h7482);
    chk("R7 clear", int'(irq), 0);
    phase = "R3";
    cmd(16'h3877);
    ticks(4);
    chk("R3 paused hold", int'(rdata), 'hFFFF);
    phase = "R2";
    cmd(16'hAB01);
    step(0, 0, 1, 16'h1234, 0);
    chk("R2 locked write ignored", int'(rdata), 'hFFFF);
    phase = "R10";
    cmd(16'h1111);
    step(0, 0, 1, 16'h0042, 0);
    chk("R10 lock persists", int'(rdata), 'hFFFF);
    cmd(16'hAB02);
    ticks(3);
    chk("R10 pause persists", int'(rdata), 'hFFFF);
    phase = "R2";
    cmd(16'hAB00);
    step(0, 0, 1, 16'h0123, 0);
    chk("R2 unlocked write", int'(rdata), 'h0123);
    phase = "R8";
    cmd(16'hDEAF);
    chk("R8 max load", int'(rdata), 'hFFFF);
    step(1, 16'hDEAF, 1, 16'h0077, 0);
    chk("R8 write beats max load", int'(rdata), 'h0077);
    phase = "R11";
    step(1, 16'hAB01, 1, 16'h0055, 0);
    chk("R11 write same cycle as lock", int'(rdata), 'h0055);
    cmd(16'hAB00);
    cmd(16'h4A4B);
    step(0, 0, 1, 16'h0020, 1);
    chk("R11 write beats tick", int'(rdata), 'h0020);
    step(1, 16'h3877, 0, 0, 1);
    chk("R11 pause effective next cycle", int'(rdata), 'h001F);
    phase = "R7";
    step(0, 0, 1, 16'h0001, 0);
    cmd(16'h4A4B);
    ticks(15);
    chk("R7 irq low before collision", int'(irq), 0);
    step(1, 16'h7482, 0, 0, 1);
    chk("R7 set wins over clear", int'(irq), 1);
    cmd(16'h7482);
    chk("R7 clear at zero", int'(irq), 0);
    phase = "R10 random";
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [15:0] c;
      r = $urandom_range(0, 15);
      case (r % 8)
        0: c = 16'hAB00; 1: c = 16'hAB01; 2: c = 16'h3877; 3: c = 16'h4A4B;
        4: c = 16'h7482; 5: c = 16'hDEAF; default: c = 16'($urandom);
      endcase
      step(($urandom_range(0, 5) == 0), c, ($urandom_range(0, 9) == 0),
           16'($urandom_range(0, 3)), ($urandom_range(0, 1) == 1));
    end
    finish_run();
  end
endmodule